// File: doc/BRIEF.md
# Infrared frame address filter

This block sits between an infrared frame receiver and the receive FIFO of a multipoint link. Each incoming frame is opened by a start-of-frame pulse, carries data bytes, and is closed by an end-of-frame pulse. The first byte after the opening pulse is the frame's address. The block compares that byte with two programmable 8-bit station addresses and decides, once per frame, whether every byte of the frame goes to the FIFO or none of them does.

A 2-bit mode selects which of the two addresses take part in the comparison. Checking can also be turned off so that every frame passes. The mode and both addresses are captured at the start-of-frame pulse. A change made while a frame is in flight therefore only affects the next frame. A start-of-frame pulse that arrives inside an open frame abandons that frame and starts a new decision. A saturating counter records how many frames were discarded.

Top module: `ir_addr_filter`

## Requirements
- R1: After reset, `fifo_wr` is 0 and `drop_count` is 0.
- R2: With `match_mode` = 2'b00, every byte of every frame is written: `fifo_wr` rises one clock after the byte is presented, and `fifo_data` equals that byte.
- R3: With `match_mode` = 2'b01, a frame is accepted exactly when its address byte equals `addr_one`.
- R4: With `match_mode` = 2'b10, a frame is accepted exactly when its address byte equals `addr_two`.
- R5: With `match_mode` = 2'b11, a frame is accepted when its address byte equals `addr_one` or `addr_two`.
- R6: In an accepted frame, the address byte and all later bytes up to the end-of-frame pulse are written. In a rejected frame, no byte is written, the address byte included.
- R7: The decision is held until `frm_end`. A byte presented together with `frm_end` still belongs to the frame. Bytes presented outside an open frame are never written.
- R8: `match_mode`, `addr_one` and `addr_two` are sampled in the cycle `frm_start` is high. This includes an address byte presented in that same cycle. Changes after that cycle do not affect the current frame.
- R9: A `frm_start` inside an open frame ends the old frame and begins a new address decision. While `frm_start` is high, `frm_end` is ignored.
- R10: `drop_count` rises by one for each rejected frame, one clock after its address byte, and holds at 2^CNT_W-1 once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A data byte is present on `byte_in` |
| byte_in | input | DW | Received data byte |
| frm_start | input | 1 | Start-of-frame pulse; the next byte (or a byte in the same cycle) is the address |
| frm_end | input | 1 | End-of-frame pulse |
| match_mode | input | 2 | Bit 0 enables `addr_one`, bit 1 enables `addr_two`; 00 accepts every frame |
| addr_one | input | DW | First station address |
| addr_two | input | DW | Second station address |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DW | Byte to write into the FIFO |
| drop_count | output | CNT_W | Saturating count of rejected frames |

## Verification
The main sweep sends a short frame for every one of the 256 address values under each of the four modes. The two station addresses are fixed and distinct. This separates exact matches from near misses and shows that each mode enables the right comparators. It also confirms that the whole frame follows the decision, not just the address byte. Further directed frames change the mode and addresses between the start pulse and the address byte. Others restart a frame in the middle, present a byte together with the start or end pulse, or send bytes after the frame has closed. These separate a decision taken on sampled configuration from one taken on live inputs. The bench runs with a 4-bit counter, so the discard count reaches its saturation value during the sweep.

// File: rtl/ir_addr_filter.sv
module ir_addr_filter #(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [DW-1:0]    byte_in,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic [1:0]       match_mode,
  input  logic [DW-1:0]    addr_one,
  input  logic [DW-1:0]    addr_two,
  output logic             fifo_wr,
  output logic [DW-1:0]    fifo_data,
  output logic [CNT_W-1:0] drop_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {IDLE, WAIT_ADDR, PASS, DROP} st_t;

  st_t           st, st_nx;
  logic [1:0]    mode_q;
  logic [DW-1:0] one_q, two_q;

  wire [1:0]    mode_e = frm_start ? match_mode : mode_q;
  wire [DW-1:0] one_e  = frm_start ? addr_one   : one_q;
  wire [DW-1:0] two_e  = frm_start ? addr_two   : two_q;

  wire deciding = byte_vld & (frm_start | (st == WAIT_ADDR));
  wire hit      = (mode_e == 2'b00)
                | (mode_e[0] & (byte_in == one_e))
                | (mode_e[1] & (byte_in == two_e));
  wire wr       = deciding ? hit : (byte_vld & (st == PASS));
  wire drop_inc = deciding & ~hit;

  always_comb begin
    st_nx = st;
    if (frm_start)
      st_nx = byte_vld ? (hit ? PASS : DROP) : WAIT_ADDR;
    else if (frm_end)
      st_nx = IDLE;
    else if (deciding)
      st_nx = hit ? PASS : DROP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      mode_q     <= 2'b00;
      one_q      <= '0;
      two_q      <= '0;
      fifo_wr    <= 1'b0;
      fifo_data  <= '0;
      drop_count <= '0;
    end else begin
      st        <= st_nx;
      fifo_wr   <= wr;
      fifo_data <= byte_in;
      if (frm_start) begin
        mode_q <= match_mode;
        one_q  <= addr_one;
        two_q  <= addr_two;
      end
      if (drop_inc && drop_count != CNT_MAX)
        drop_count <= drop_count + 1'b1;
    end
  end

  assert_data_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_data == $past(byte_in)));

  assert_open_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && frm_start && match_mode == 2'b00) |=> fifo_wr);

  assert_either_address_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && frm_start && match_mode == 2'b11 && (byte_in == addr_one || byte_in == addr_two)) |=> fifo_wr);

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DROP && !frm_start) |=> !fifo_wr);

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && !frm_start) |=> !fifo_wr);

  assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != CNT_MAX) |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));

endmodule

// File: tb/test_ir_addr_filter.sv
module test_ir_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_vld, frm_start, frm_end;
  logic [7:0] byte_in, addr_one, addr_two;
  logic [1:0] match_mode;
  logic       fifo_wr;
  logic [7:0] fifo_data;
  logic [3:0] drop_count;

  int checks = 0;
  int errors = 0;
  int drops  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ir_addr_filter #(.DW(8), .CNT_W(4)) i_ir_addr_filter (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .frm_start(frm_start), .frm_end(frm_end), .match_mode(match_mode),
    .addr_one(addr_one), .addr_two(addr_two), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .drop_count(drop_count));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic s, input logic e,
                      input logic exp_wr, input string tag);
    byte_vld = v; byte_in = d; frm_start = s; frm_end = e;
    @(posedge clk); #1;
    chk(fifo_wr == exp_wr, {tag, " wr"}, fifo_wr, exp_wr);
    if (exp_wr) chk(fifo_data == d, {tag, " data"}, fifo_data, d);
  endtask

  function automatic bit accepts(input logic [1:0] m, input logic [7:0] a,
                                 input logic [7:0] x1, input logic [7:0] x2);
    return (m == 2'b00) || (m[0] && a == x1) || (m[1] && a == x2);
  endfunction

  task automatic count_chk(input string tag);
    int exp = (drops > 15) ? 15 : drops;
    chk(drop_count == exp[3:0], tag, drop_count, exp);
  endtask

  task automatic frame(input logic [1:0] m, input logic [7:0] a, input string tag);
    bit acc = accepts(m, a, 8'h5A, 8'hA5);
    match_mode = m; addr_one = 8'h5A; addr_two = 8'hA5;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, tag);
    step(1'b1, a, 1'b0, 1'b0, acc, {tag, "/R6 addr"});
    if (!acc) drops++;
    count_chk("R10 count");
    step(1'b1, a ^ 8'hFF, 1'b0, 1'b0, acc, {tag, "/R6 body"});
    step(1'b1, a + 8'd3, 1'b0, 1'b0, acc, {tag, "/R6 body"});
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; byte_vld = 0; byte_in = 0; frm_start = 0; frm_end = 0;
    match_mode = 0; addr_one = 0; addr_two = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(fifo_wr == 1'b0, "R1 wr", fifo_wr, 0);
    chk(drop_count == 4'd0, "R1 count", drop_count, 0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 256; a++)
        frame(m[1:0], a[7:0], m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5");

    match_mode = 2'b00;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 8'h41, 1'b0, 1'b0, 1'b1, "R7 addr");
    step(1'b1, 8'h42, 1'b0, 1'b1, 1'b1, "R7 byte with end");
    step(1'b1, 8'h43, 1'b0, 1'b0, 1'b0, "R7 after end");
    step(1'b1, 8'h44, 1'b0, 1'b0, 1'b0, "R7 after end");

    match_mode = 2'b01; addr_one = 8'h11; addr_two = 8'h77;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8");
    match_mode = 2'b10; addr_one = 8'h22;
    step(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, "R8 sampled config");
    match_mode = 2'b11; addr_two = 8'h00;
    step(1'b1, 8'h12, 1'b0, 1'b0, 1'b1, "R8 mid change");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R8");

    match_mode = 2'b00;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8");
    match_mode = 2'b01; addr_one = 8'h33;
    step(1'b1, 8'h44, 1'b0, 1'b0, 1'b1, "R8 open latched");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R8");

    match_mode = 2'b01; addr_one = 8'h33;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8");
    match_mode = 2'b00;
    step(1'b1, 8'h44, 1'b0, 1'b0, 1'b0, "R8 filter latched");
    drops++;
    step(1'b1, 8'h45, 1'b0, 1'b1, 1'b0, "R8 filter latched");

    match_mode = 2'b10; addr_two = 8'h66;
    step(1'b1, 8'h66, 1'b1, 1'b0, 1'b1, "R8 same-cycle addr");
    step(1'b1, 8'h67, 1'b0, 1'b1, 1'b1, "R8 same-cycle body");

    match_mode = 2'b01; addr_one = 8'h11;
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, "R9 first addr");
    step(1'b1, 8'h21, 1'b0, 1'b0, 1'b1, "R9 first body");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R9 restart");
    step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0, "R9 new addr");
    drops++;
    step(1'b1, 8'h9A, 1'b0, 1'b0, 1'b0, "R9 new body");
    step(1'b1, 8'h11, 1'b1, 1'b0, 1'b1, "R9 restart with addr");
    step(1'b1, 8'h12, 1'b0, 1'b0, 1'b1, "R9 body");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R9");
    count_chk("R10 final");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule